// File: doc/BRIEF.md
# Interrupt Request and Priority Unit

This block holds the pending-interrupt status of a processor core. Interrupt sources update the pending field one line at a time through a line-update port that carries a line number and its level. A per-line enable mask and a single global enable then decide whether the core should take an interrupt. When an interrupt is to be taken, the block also gives the number of the highest pending line.

Thirteen lines are supported. Lines 0 and 1 are software lines that the core writes through the same port. Lines 2 to 9 are external hardware lines, line 10 is the timer, line 11 is the performance counter and line 12 is the inter-processor line. A higher line number has higher priority. While the core is in debug mode, taking an interrupt is blocked. The wake-up indication (has-work) ignores both the global enable and debug mode, so a sleeping core still wakes on a masked-in request.

Top module: `irq_prio_unit`

## Requirements
- R1: A line update with number n in 0..12 sets pending bit n to the supplied level. The new value is visible on `pending` after the next rising clock edge, and all other bits keep their values.
- R2: A line update with a number in 13..31 changes no pending bit.
- R3: `hard_req` is 1 exactly when at least one pending bit is set.
- R4: `has_work` is 1 exactly when `pending AND local-enable` is non-zero. Neither the global enable nor `dbg_mode` affects it.
- R5: `take_irq` is registered. After a rising edge it is 1 exactly when, just before that edge, the global enable was 1, `dbg_mode` was 0 and `pending AND local-enable` was non-zero.
- R6: A cycle with `dbg_mode` high is followed by `take_irq` low, whatever the other state.
- R7: `vec_idx` is the index of the most significant set bit of `pending AND local-enable`, and it is 0 when that value is zero.
- R8: Reset clears the pending field, the local-enable field, the global enable and `take_irq`.
- R9: A write to the local-enable field replaces all 13 bits, and a write to the global enable replaces that bit. Both take effect at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| line_vld | input | 1 | Line-update strobe |
| line_num | input | 5 | Line number of the update |
| line_lvl | input | 1 | New level of the addressed line |
| lie_we | input | 1 | Local-enable field write strobe |
| lie_wdata | input | 13 | New local-enable field |
| gie_we | input | 1 | Global-enable write strobe |
| gie_wdata | input | 1 | New global-enable value |
| dbg_mode | input | 1 | Core is in debug mode |
| pending | output | 13 | Pending field |
| hard_req | output | 1 | Any pending bit set |
| has_work | output | 1 | A masked-in interrupt is pending |
| take_irq | output | 1 | Registered take-interrupt indication |
| vec_idx | output | 4 | Highest-priority masked-in pending line |

## Verification
The hardest case to reach from the ports is a pending line that is masked in while the global enable is set and debug mode is raised in the same cycle. Here `has_work` must be high and `take_irq` must fall one edge later. The random stimulus keeps the enable and line traffic dense and raises `dbg_mode` in about one cycle in five, so this combination comes up often. Directed sequences also walk every line through the priority encoder, and send line numbers 13 to 31 while the pending field is non-zero, so that any wrongly accepted update would change a visible bit.

// File: rtl/irqpu_pkg.sv
package irqpu_pkg;
  parameter int unsigned PEND_BITS = 13;
  parameter int unsigned NUM_W     = 5;
  parameter int unsigned VEC_W     = $clog2(PEND_BITS);
endpackage

// File: rtl/irqpu_pend_reg.sv
module irqpu_pend_reg #(
  parameter int unsigned N  = irqpu_pkg::PEND_BITS,
  parameter int unsigned IW = irqpu_pkg::NUM_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_vld,
  input  logic [IW-1:0] line_num,
  input  logic          line_lvl,
  output logic [N-1:0]  pend
);
  logic [N-1:0] pend_q;
  logic [N-1:0] pend_d;
  logic [N-1:0] hit;

  for (genvar g = 0; g < N; g++) begin : g_bit
    assign hit[g] = line_vld && (line_num == IW'(g));

    always_comb begin
      pend_d[g] = pend_q[g];
      if (hit[g]) pend_d[g] = line_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend_q[g] <= 1'b0;
      else if (hit[g]) pend_q[g] <= pend_d[g];
    end
  end

  assign pend = pend_q;

  // R2
  oor_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_vld && (line_num >= IW'(N))) |=> $stable(pend_q));

  // R1
  line_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_vld && (line_num < IW'(N))) |=> (pend_q[$past(line_num)] == $past(line_lvl)));
endmodule

// File: rtl/irqpu_prio_enc.sv
module irqpu_prio_enc #(
  parameter int unsigned N  = irqpu_pkg::PEND_BITS,
  parameter int unsigned VW = irqpu_pkg::VEC_W
) (
  input  logic [N-1:0]  masked,
  output logic          any,
  output logic [VW-1:0] vec
);
  always_comb begin
    vec = '0;
    for (int i = 0; i < N; i++) begin
      if (masked[i]) vec = VW'(i);
    end
  end

  assign any = |masked;

  always_comb begin
    if (!$isunknown(masked)) begin
      // R7
      msb_pick_chk: assert ((masked == '0) ? (vec == '0) : ((masked >> vec) == N'(1)));
    end
  end
endmodule

// File: rtl/irq_prio_unit.sv
module irq_prio_unit #(
  parameter int unsigned N  = irqpu_pkg::PEND_BITS,
  parameter int unsigned IW = irqpu_pkg::NUM_W,
  parameter int unsigned VW = irqpu_pkg::VEC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_vld,
  input  logic [IW-1:0] line_num,
  input  logic          line_lvl,
  input  logic          lie_we,
  input  logic [N-1:0]  lie_wdata,
  input  logic          gie_we,
  input  logic          gie_wdata,
  input  logic          dbg_mode,
  output logic [N-1:0]  pending,
  output logic          hard_req,
  output logic          has_work,
  output logic          take_irq,
  output logic [VW-1:0] vec_idx
);
  logic [N-1:0] lie_q, lie_d;
  logic         gie_q, gie_d;
  logic         take_q, take_d;
  logic [N-1:0] masked;
  logic         any_masked;

  irqpu_pend_reg #(.N(N), .IW(IW)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_vld (line_vld),
    .line_num (line_num),
    .line_lvl (line_lvl),
    .pend     (pending)
  );

  assign masked = pending & lie_q;

  irqpu_prio_enc #(.N(N), .VW(VW)) u_enc (
    .masked (masked),
    .any    (any_masked),
    .vec    (vec_idx)
  );

  always_comb begin
    lie_d  = lie_we ? lie_wdata : lie_q;
    gie_d  = gie_we ? gie_wdata : gie_q;
    take_d = gie_q && !dbg_mode && any_masked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lie_q  <= '0;
      gie_q  <= 1'b0;
      take_q <= 1'b0;
    end else begin
      if (lie_we) lie_q <= lie_d;
      if (gie_we) gie_q <= gie_d;
      take_q <= take_d;
    end
  end

  assign hard_req = |pending;
  assign has_work = hard_req && any_masked;
  assign take_irq = take_q;

  // R6
  dbg_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_mode |=> !take_irq);

  // R5
  take_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take_irq) |-> $past(gie_q && has_work));

  // R9
  lie_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lie_we |=> (lie_q == $past(lie_wdata)));

  // R9
  gie_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gie_we |=> (gie_q == $past(gie_wdata)));
endmodule

// File: tb/irq_prio_unit_tb.sv
module irq_prio_unit_tb;
  localparam int N = 13;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        line_vld, line_lvl, lie_we, gie_we, gie_wdata, dbg_mode;
  logic [4:0]  line_num;
  logic [12:0] lie_wdata;
  logic [12:0] pending;
  logic        hard_req, has_work, take_irq;
  logic [3:0]  vec_idx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [12:0] pend_m, lie_m;
  logic        gie_m;

  always #5 clk = ~clk;

  irq_prio_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .line_vld(line_vld), .line_num(line_num), .line_lvl(line_lvl),
    .lie_we(lie_we), .lie_wdata(lie_wdata),
    .gie_we(gie_we), .gie_wdata(gie_wdata),
    .dbg_mode(dbg_mode),
    .pending(pending), .hard_req(hard_req), .has_work(has_work),
    .take_irq(take_irq), .vec_idx(vec_idx)
  );

  function automatic logic [3:0] top_bit(input logic [12:0] v);
    logic [3:0] r = 4'd0;
    for (int i = 0; i < N; i++) if (v[i]) r = 4'(i);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic sv, input logic [4:0] sn, input logic sl,
                      input logic lw, input logic [12:0] ld,
                      input logic gw, input logic gd, input logic dbg);
    logic take_exp;
    logic [12:0] m;
    line_vld = sv; line_num = sn; line_lvl = sl;
    lie_we = lw; lie_wdata = ld; gie_we = gw; gie_wdata = gd; dbg_mode = dbg;
    take_exp = gie_m && !dbg && ((pend_m & lie_m) != 0);
    if (sv && sn < 5'd13) pend_m[sn] = sl;
    if (lw) lie_m = ld;
    if (gw) gie_m = gd;
    @(posedge clk);
    @(negedge clk);
    m = pend_m & lie_m;
    if (sv && sn >= 5'd13) chk(pending === pend_m, "R2", int'(pending), int'(pend_m));
    else                   chk(pending === pend_m, "R1", int'(pending), int'(pend_m));
    chk(hard_req === (pend_m != 0), "R3", int'(hard_req), int'(pend_m != 0));
    // has_work depends on the local-enable written per R9
    chk(has_work === (m != 0), "R4", int'(has_work), int'(m != 0));
    chk(vec_idx === top_bit(m), "R7", int'(vec_idx), int'(top_bit(m)));
    if (dbg) chk(take_irq === 1'b0, "R6", int'(take_irq), 0);
    else     chk(take_irq === take_exp, "R5", int'(take_irq), int'(take_exp));
  endtask

  task automatic idle(input logic dbg);
    step(1'b0, 5'd0, 1'b0, 1'b0, 13'd0, 1'b0, 1'b0, dbg);
  endtask

  task automatic reset_check();
    chk(pending === 13'd0, "R8", int'(pending), 0);
    chk(take_irq === 1'b0, "R8", int'(take_irq), 0);
    chk(has_work === 1'b0, "R8", int'(has_work), 0);
    chk(vec_idx === 4'd0, "R8", int'(vec_idx), 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    line_vld = 0; line_num = 0; line_lvl = 0; lie_we = 0; lie_wdata = 0;
    gie_we = 0; gie_wdata = 0; dbg_mode = 0;
    pend_m = 0; lie_m = 0; gie_m = 0;
    repeat (3) @(negedge clk);
    reset_check();
    rst_n = 1'b1;
    @(negedge clk);
    reset_check();

    // R8: enables cleared by reset, so a pending line gives no work
    step(1'b1, 5'd5, 1'b1, 1'b0, 13'd0, 1'b0, 1'b0, 1'b0);

    // R7: walk each line alone through the encoder, all enabled
    step(1'b1, 5'd5, 1'b0, 1'b1, 13'h1FFF, 1'b1, 1'b1, 1'b0);
    for (int k = 0; k < N; k++) begin
      step(1'b1, 5'(k), 1'b1, 1'b0, 13'd0, 1'b0, 1'b0, 1'b0);
      idle(1'b0);
      step(1'b1, 5'(k), 1'b0, 1'b0, 13'd0, 1'b0, 1'b0, 1'b0);
    end

    // R2: out-of-range numbers while bits are pending
    step(1'b1, 5'd3, 1'b1, 1'b0, 13'd0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 5'd12, 1'b1, 1'b0, 13'd0, 1'b0, 1'b0, 1'b0);
    for (int k = 13; k < 32; k++) step(1'b1, 5'(k), 1'b0, 1'b0, 13'd0, 1'b0, 1'b0, 1'b0);
    for (int k = 13; k < 32; k++) step(1'b1, 5'(k), 1'b1, 1'b0, 13'd0, 1'b0, 1'b0, 1'b0);

    // R6 and R4: debug blocks take, has-work stays
    idle(1'b1); idle(1'b1); idle(1'b0);
    // R4: global enable off keeps has-work
    step(1'b0, 5'd0, 1'b0, 1'b0, 13'd0, 1'b1, 1'b0, 1'b0);
    idle(1'b0);
    // R9: mask out bit 12 only, vector moves to 3
    step(1'b0, 5'd0, 1'b0, 1'b1, 13'h0FFF, 1'b1, 1'b1, 1'b0);
    idle(1'b0);

    // random traffic
    for (int c = 0; c < 3000; c++) begin
      logic [4:0] sn;
      sn = ($urandom_range(0, 7) == 0) ? 5'($urandom_range(13, 31)) : 5'($urandom_range(0, 12));
      step(1'($urandom_range(0, 3) != 0), sn, 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 9) == 0), 13'($urandom),
           1'($urandom_range(0, 7) == 0), 1'($urandom_range(0, 3) != 0),
           1'($urandom_range(0, 4) == 0));
    end

    // R8: reset in the middle of activity
    step(1'b1, 5'd9, 1'b1, 1'b1, 13'h1FFF, 1'b1, 1'b1, 1'b0);
    rst_n = 1'b0;
    pend_m = 0; lie_m = 0; gie_m = 0;
    @(negedge clk);
    reset_check();
    rst_n = 1'b1;
    step(1'b1, 5'd1, 1'b1, 1'b0, 13'd0, 1'b0, 1'b0, 1'b0);
    idle(1'b0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule